// File: doc/BRIEF.md
# Sleep-Wake and Watchdog Interval Timer

This block keeps a free-running 15-bit count of ticks from an always-on low-speed oscillator (about 32 kHz). Each tick arrives as a pulse from another clock domain. It passes through a synchronizer and an edge detector, so that every tick advances the count exactly once in the system clock domain. From the count the block produces a periodic sleep-wake interrupt at one of four intervals, from about 1.95 ms (64 ticks) up to 1 s (32768 ticks).

The same interval events drive a watchdog. While the watchdog is enabled it counts wake events. When three events pass without a clear from software, it raises a reset request. The request stays high until the block is reset. All pins are plain control and status signals: the block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `sleep_wdt_timer`

## Requirements
- R1: Each rising edge of `lf_tick_i` advances the count by exactly one, however long the tick stays high. A tick first sampled high at clock edge k takes effect at edge k+2. The tick must be sampled low for at least one edge between two ticks.
- R2: `ivl_sel_i` selects the wake interval: 0 gives 64 ticks, 1 gives 512, 2 gives 4096 and 3 gives 32768. An event occurs on the tick that brings the count bits below that interval to zero. After a reset, events for setting 0 fall on ticks 64, 128, 192 and so on.
- R3: `sleep_irq_o` is high for exactly one system clock per event, in the same cycle the count reaches the boundary.
- R4: The interval in force is sampled from `ivl_sel_i` during reset, and afterwards only on the tick where the full 15-bit count wraps to zero. A change at any other time has no effect until that wrap.
- R5: With `wdt_en_i` high, `wdt_rst_req_o` rises in the same cycle as the third wake event counted since the last clear, enable or reset. Once high, it stays high until reset.
- R6: A high `wdt_clr_i` sets the watchdog's event count to zero. When a clear and a wake event fall in the same cycle, the clear wins and the event is not counted.
- R7: A synchronous reset (`rst_i` high) clears the tick count, the synchronizer, the watchdog event count and both outputs. The outputs are low in the cycle after a reset edge.
- R8: With `wdt_en_i` low, the watchdog event count is held at zero and no reset request is raised. The tick count and the wake events go on regardless.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| lf_tick_i | input | 1 | Tick pulse from the low-speed oscillator, asynchronous |
| ivl_sel_i | input | 2 | Wake interval select |
| wdt_en_i | input | 1 | Watchdog enable |
| wdt_clr_i | input | 1 | Watchdog clear strobe |
| sleep_irq_o | output | 1 | One-cycle wake interrupt pulse |
| wdt_rst_req_o | output | 1 | Sticky watchdog reset request |

## Verification
A watchdog clear and a wake event can land in the same system clock cycle, and the clear must win. The bench provokes this by raising the clear just before the tick that completes an interval and holding it across the cycle in which that tick takes effect. It then checks that the next two events leave the request low and that only the third one raises it. Throughout, a behavioural model predicts both outputs on every clock. The model knows the tick latency and the deferred interval switch, and its predictions are compared with the outputs.

// File: rtl/sleep_wdt_pkg.sv
package sleep_wdt_pkg;
  typedef enum logic [1:0] {
    IVL_SHORT  = 2'd0,
    IVL_MID    = 2'd1,
    IVL_LONG   = 2'd2,
    IVL_FULL   = 2'd3
  } ivl_sel_e;

  // Width of the low-order field that must be zero for an event.
  function automatic int unsigned boundary_bits(input ivl_sel_e sel,
                                                input int unsigned base_log2,
                                                input int unsigned step_log2);
    return base_log2 + step_log2 * int'(sel);
  endfunction
endpackage

// File: rtl/lf_tick_sync.sv
module lf_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_async_i,
  output logic tick_en_o
);
  localparam int unsigned CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= '0;
    else       chain_q <= {chain_q[CHAIN-2:0], tick_async_i};
  end

  // Rising edge of the synchronized level.
  assign tick_en_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_en_o |=> !tick_en_o);
endmodule

// File: rtl/ivl_counter.sv
module ivl_counter
  import sleep_wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 15,
  parameter int unsigned BASE_LOG2 = 6,
  parameter int unsigned STEP_LOG2 = 3
) (
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     tick_en_i,
  input  ivl_sel_e sel_i,
  output logic     evt_o,
  output logic     irq_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, low_mask;
  ivl_sel_e         sel_q;
  logic             wrap;
  int unsigned      edge_bits;

  assign cnt_nxt   = cnt_q + 1'b1;
  assign edge_bits = boundary_bits(sel_q, BASE_LOG2, STEP_LOG2);

  for (genvar gb = 0; gb < int'(CNT_W); gb++) begin : g_mask
    assign low_mask[gb] = (gb < edge_bits);
  end

  assign wrap  = tick_en_i && (cnt_q == CNT_TOP);
  assign evt_o = tick_en_i && ((cnt_nxt & low_mask) == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      sel_q <= sel_i;
      irq_o <= 1'b0;
    end else begin
      irq_o <= evt_o;
      if (tick_en_i) cnt_q <= cnt_nxt;
      if (wrap)      sel_q <= sel_i;
    end
  end

  a_r1_count_step: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_en_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  a_r4_sel_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
    !wrap |=> sel_q == $past(sel_q));
  a_r2_irq_on_boundary: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> ((cnt_q & low_mask) == '0));
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic clr_i,
  input  logic evt_i,
  output logic req_o
);
  localparam int unsigned EW = $clog2(LIMIT + 1);
  localparam logic [EW-1:0] LAST = EW'(LIMIT - 1);

  logic [EW-1:0] seen_q;
  logic          bump;

  assign bump = en_i && !clr_i && evt_i && (seen_q <= LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      seen_q <= '0;
      req_o  <= 1'b0;
    end else begin
      if (!en_i || clr_i) seen_q <= '0;
      else if (bump)      seen_q <= seen_q + 1'b1;
      if (bump && seen_q == LAST) req_o <= 1'b1;
    end
  end

  a_r5_req_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    req_o |=> req_o);
  a_r6_clear_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> seen_q == '0);
  a_r8_off_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i && !req_o) |=> !req_o);
endmodule

// File: rtl/sleep_wdt_timer.sv
module sleep_wdt_timer
  import sleep_wdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 15,
  parameter int unsigned BASE_LOG2   = 6,
  parameter int unsigned STEP_LOG2   = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WDT_LIMIT   = 3
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       lf_tick_i,
  input  logic [1:0] ivl_sel_i,
  input  logic       wdt_en_i,
  input  logic       wdt_clr_i,
  output logic       sleep_irq_o,
  output logic       wdt_rst_req_o
);
  logic tick_en, ivl_evt;

  lf_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .tick_async_i(lf_tick_i), .tick_en_o(tick_en)
  );

  ivl_counter #(.CNT_W(CNT_W), .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .tick_en_i(tick_en),
    .sel_i(ivl_sel_e'(ivl_sel_i)), .evt_o(ivl_evt), .irq_o(sleep_irq_o)
  );

  wdt_core #(.LIMIT(WDT_LIMIT)) u_wdt (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(wdt_en_i), .clr_i(wdt_clr_i),
    .evt_i(ivl_evt), .req_o(wdt_rst_req_o)
  );

  a_r3_irq_width: assert property (@(posedge clk_i) disable iff (rst_i)
    sleep_irq_o |=> !sleep_irq_o);
  a_r7_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (!sleep_irq_o && !wdt_rst_req_o));
endmodule

// File: tb/test_sleep_wdt_timer.sv
module test_sleep_wdt_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [1:0] sel = 2'd0;
  logic wen = 1'b0;
  logic wclr = 1'b0;
  logic irq, req;

  int checks = 0;
  int fails = 0;
  int irq_seen = 0;

  // model state
  int h0 = 0, h1 = 0, h2 = 0;
  int mcnt = 0, msel = 0, mwc = 0;
  bit mirq = 0, mreq = 0;

  always #5 clk = ~clk;

  sleep_wdt_timer i_sleep_wdt_timer (
    .clk_i(clk), .rst_i(rst), .lf_tick_i(tick), .ivl_sel_i(sel),
    .wdt_en_i(wen), .wdt_clr_i(wclr), .sleep_irq_o(irq), .wdt_rst_req_o(req)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated at every rising edge.
  always @(posedge clk) begin
    if (rst) begin
      h0 = 0; h1 = 0; h2 = 0;
      mcnt = 0; msel = int'(sel); mwc = 0; mirq = 0; mreq = 0;
    end else begin
      mirq = 0;
      if (h1 == 1 && h2 == 0) begin
        mcnt = (mcnt + 1) % 32768;
        if (mcnt % (64 << (3 * msel)) == 0) mirq = 1;
        if (mcnt == 0) msel = int'(sel);
      end
      if (!wen || wclr) mwc = 0;
      else if (mirq && mwc < 3) begin
        mwc++;
        if (mwc == 3) mreq = 1;
      end
      h2 = h1; h1 = h0; h0 = int'(tick);
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    check(irq === mirq, "R2/R3 sleep_irq", int'(irq), int'(mirq));
    check(req === mreq, "R5/R6 wdt_rst_req", int'(req), int'(mreq));
    if (!rst && irq) irq_seen++;
  end

  task automatic send_tick(input int hi, input int lo);
    @(negedge clk) tick = 1'b1;
    repeat (hi - 1) @(negedge clk);
    @(negedge clk) tick = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) send_tick(1, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk) begin rst = 1'b1; sel = s; end
    repeat (2) @(negedge clk);
    rst = 1'b0;
    irq_seen = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R7: reset state
    do_reset(2'd0);
    @(negedge clk);
    check(irq == 1'b0 && req == 1'b0, "R7 outputs after reset", int'(irq) + int'(req), 0);

    // R1/R2: wide and narrow ticks, shortest interval
    for (int i = 0; i < 63; i++) send_tick(1 + (i % 4), 1 + (i % 3));
    repeat (3) @(negedge clk);
    check(irq_seen == 0, "R1 no event before tick 64", irq_seen, 0);
    send_tick(5, 3);
    repeat (3) @(negedge clk);
    check(irq_seen == 1, "R1 wide tick counted once, event at 64", irq_seen, 1);
    ticks(86);
    check(irq_seen == 2, "R2 two events in 150 ticks", irq_seen, 2);

    // R7: reset mid-interval restarts the count
    ticks(30);
    do_reset(2'd0);
    ticks(63);
    check(irq_seen == 0, "R7 count cleared by reset", irq_seen, 0);
    ticks(1);
    check(irq_seen == 1, "R7 first event 64 ticks after reset", irq_seen, 1);

    // R5: watchdog trips on third event and stays
    do_reset(2'd0);
    wen = 1'b1;
    ticks(191);
    check(req == 1'b0, "R5 no request after two events", int'(req), 0);
    ticks(1);
    check(req == 1'b1, "R5 request on third event", int'(req), 1);
    ticks(70);
    check(req == 1'b1, "R5 request sticky", int'(req), 1);

    // R6: clear, then clear colliding with an event
    do_reset(2'd0);
    ticks(128);
    @(negedge clk) wclr = 1'b1;
    @(negedge clk) wclr = 1'b0;
    ticks(191);
    check(req == 1'b0, "R6 clear restarts count", int'(req), 0);
    @(negedge clk) wclr = 1'b1;
    send_tick(1, 4);
    @(negedge clk) wclr = 1'b0;
    repeat (3) @(negedge clk);
    check(irq_seen == 5, "R6 colliding event still pulses irq", irq_seen, 5);
    ticks(128);
    check(req == 1'b0, "R6 clear won over same-cycle event", int'(req), 0);
    ticks(64);
    check(req == 1'b1, "R6 third event after collision trips", int'(req), 1);

    // R8: disabled watchdog stays quiet, count held at zero
    do_reset(2'd0);
    wen = 1'b0;
    ticks(256);
    check(req == 1'b0 && irq_seen == 4, "R8 events run, no request", int'(req), 0);
    wen = 1'b1;
    ticks(128);
    check(req == 1'b0, "R8 count was held at zero", int'(req), 0);
    ticks(64);
    check(req == 1'b1, "R8 trips after three enabled events", int'(req), 1);

    // R4: select change deferred to full wrap
    wen = 1'b0;
    do_reset(2'd1);
    ticks(600);
    check(irq_seen == 1, "R2 512-tick interval", irq_seen, 1);
    sel = 2'd2;
    ticks(32768 - 600);
    check(irq_seen == 64, "R4 old interval kept until wrap", irq_seen, 64);
    ticks(4095);
    check(irq_seen == 64, "R4 new interval after wrap", irq_seen, 64);
    ticks(1);
    check(irq_seen == 65, "R4 4096-tick event", irq_seen, 65);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule